// File: doc/BRIEF.md
# Addressable Serial Receiver with Sleep Filter

This block receives asynchronous serial frames of 7, 8 or 9 data bits, sent least significant bit first, with an optional even or odd parity bit and one stop bit. A free-running baud tick at sixteen times the bit rate drives a mid-bit sampler. Each frame it accepts is loaded into a receive buffer, and a set of register-style status flags records completion, overrun, framing and parity errors, plus a summary error. Software clears these flags with a buffer read strobe or by writing 0 to the receive-enable bit.

Several nodes can share one line using sleep mode. While sleep is set, a frame whose most significant data bit is 0 is dropped with no trace. A frame whose top bit is 1 (an address frame) is received normally. A node that recognises its address clears its sleep bit and takes the data frames that follow. A single interrupt-request output pulses either for every accepted frame or only for frames that carry an error.

Top module: `uart_sleep_rx`

## Requirements
- R1: A frame is a low start bit, then N data bits LSB first, where len_sel_i 0 selects N=7, 1 selects N=8 and 2 or 3 select N=9. An optional parity bit follows, then a stop bit. Once accepted, the data appears on rbuf_o[N-1:0] with all higher bits 0, and ri_o is set.
- R2: A low pulse is taken as a start bit only if the line is still low at its midpoint, which is half a bit after it was first seen. A shorter low glitch changes no output.
- R3: With par_en_i=1 the bit after the data is parity. par_odd_i=0 requires an even count of ones over data plus parity, and par_odd_i=1 requires an odd count. A mismatch sets per_o. With par_en_i=0, per_o is never set.
- R4: A stop bit sampled low sets fer_o.
- R5: sum_o is set in the same cycle as any of oer_o, fer_o or per_o.
- R6: A pulse on rbuf_rd_i clears ri_o, fer_o, per_o and sum_o. It leaves oer_o unchanged.
- R7: If a frame is accepted while ri_o is still set and no read occurs in that cycle, oer_o and sum_o are set, while rbuf_o, ri_o, fer_o and per_o keep their values.
- R8: re_wr_i with re_wdata_i loads re_o. Writing 0 clears oer_o, fer_o, per_o and sum_o, leaves ri_o alone, and stops reception. While re_o is 0, frames are ignored.
- R9: With irq_err_only_i=0, irq_o pulses for one cycle when an accepted frame sets ri_o from 0. An overrun frame gives no pulse in this mode.
- R10: With irq_err_only_i=1, irq_o pulses only for an accepted frame that has a framing error, a parity error or an overrun.
- R11: With sleep_i=1, a frame whose top data bit (bit N-1) is 0 changes neither the buffer nor any flag and raises no interrupt. This holds even while ri_o is set.
- R12: With sleep_i=1, a frame whose top data bit is 1 is received exactly as with sleep_i=0. For N=7, 8 and 9, the top data bit is bit 6, 7 and 8 respectively.
- R13: After reset, rbuf_o is 0, all flags and re_o are 0, and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | One-cycle tick at 16x the bit rate |
| rx_i | input | 1 | Serial line, idle high |
| len_sel_i | input | 2 | Data length: 0=7, 1=8, 2/3=9 bits |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 0 even, 1 odd parity |
| sleep_i | input | 1 | Sleep filter enable |
| irq_err_only_i | input | 1 | Interrupt on errors only |
| rbuf_rd_i | input | 1 | Receive buffer read strobe |
| re_wr_i | input | 1 | Write strobe for the receive-enable bit |
| re_wdata_i | input | 1 | Value written to receive enable |
| rbuf_o | output | 9 | Receive buffer |
| re_o | output | 1 | Receive enable |
| ri_o | output | 1 | Receive complete |
| oer_o | output | 1 | Overrun error |
| fer_o | output | 1 | Framing error |
| per_o | output | 1 | Parity error |
| sum_o | output | 1 | Summary error |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The bench uses the default sixteen-times oversampling and a nine-bit buffer width. This lets all three frame lengths run, so the top-bit position used by the sleep filter can be checked at bits 6, 7 and 8. The baud tick fires every fourth clock, which keeps each frame near 700 cycles. It also leaves room for the sampling point to drift by a few clocks within a bit, for a glitch shorter than half a bit, and for a framing-error stop bit that returns high before a false start can be confirmed.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_state_e;

  function automatic int frame_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 7;
      2'd1:    return 8;
      default: return 9;
    endcase
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int W   = 9,
  localparam int CW = $clog2(OSR),
  localparam int IW = $clog2(W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          rx_i,
  input  logic [IW-1:0] nbits_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  output logic          done_o,
  output logic [W-1:0]  data_o,
  output logic          ferr_o,
  output logic          perr_o
);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);

  rx_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic [W-1:0]  sh_q;
  logic          par_q, done_q, ferr_q, perr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      done_q <= 1'b0;
      ferr_q <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        st_q <= RX_IDLE;
      end else if (tick_i) begin
        case (st_q)
          RX_IDLE: if (!rx_i) begin
            st_q  <= RX_START;
            cnt_q <= '0;
          end
          RX_START: begin
            if (cnt_q == MID) begin
              // midpoint still low: real start bit
              st_q   <= rx_i ? RX_IDLE : RX_DATA;
              cnt_q  <= '0;
              idx_q  <= '0;
              sh_q   <= '0;
              par_q  <= 1'b0;
              perr_q <= 1'b0;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_DATA: begin
            if (cnt_q == LAST) begin
              cnt_q       <= '0;
              sh_q[idx_q] <= rx_i;
              par_q       <= par_q ^ rx_i;
              if (idx_q == nbits_i - IW'(1)) st_q <= par_en_i ? RX_PAR : RX_STOP;
              else                            idx_q <= idx_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_PAR: begin
            if (cnt_q == LAST) begin
              cnt_q  <= '0;
              perr_q <= par_q ^ rx_i ^ par_odd_i;
              st_q   <= RX_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_STOP: begin
            if (cnt_q == LAST) begin
              cnt_q  <= '0;
              ferr_q <= !rx_i;
              done_q <= 1'b1;
              st_q   <= RX_IDLE;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign done_o = done_q;
  assign data_o = sh_q;
  assign ferr_o = ferr_q;
  assign perr_o = perr_q;
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         done_i,
  input  logic [W-1:0] data_i,
  input  logic         top_i,
  input  logic         ferr_i,
  input  logic         perr_i,
  input  logic         sleep_i,
  input  logic         err_only_i,
  input  logic         rd_i,
  input  logic         re_wr_i,
  input  logic         re_wdata_i,
  output logic [W-1:0] rbuf_o,
  output logic         re_o,
  output logic         ri_o,
  output logic         oer_o,
  output logic         fer_o,
  output logic         per_o,
  output logic         sum_o,
  output logic         irq_o
);
  logic [W-1:0] rbuf_q;
  logic re_q, ri_q, oer_q, fer_q, per_q, sum_q, irq_q;
  logic accept;

  // sleep filter: only frames with top data bit set pass
  assign accept = done_i && re_q && (!sleep_i || top_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbuf_q <= '0;
      re_q   <= 1'b0;
      ri_q   <= 1'b0;
      oer_q  <= 1'b0;
      fer_q  <= 1'b0;
      per_q  <= 1'b0;
      sum_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (re_wr_i) begin
        re_q <= re_wdata_i;
        if (!re_wdata_i) begin
          oer_q <= 1'b0;
          fer_q <= 1'b0;
          per_q <= 1'b0;
          sum_q <= 1'b0;
        end
      end
      if (rd_i) begin
        ri_q  <= 1'b0;
        fer_q <= 1'b0;
        per_q <= 1'b0;
        sum_q <= 1'b0;
      end
      if (accept) begin
        if (ri_q && !rd_i) begin
          oer_q <= 1'b1;
          sum_q <= 1'b1;
          irq_q <= err_only_i;
        end else begin
          rbuf_q <= data_i;
          ri_q   <= 1'b1;
          fer_q  <= ferr_i;
          per_q  <= perr_i;
          sum_q  <= ferr_i | perr_i;
          irq_q  <= !err_only_i | ferr_i | perr_i;
        end
      end
    end
  end

  assign rbuf_o = rbuf_q;
  assign re_o   = re_q;
  assign ri_o   = ri_q;
  assign oer_o  = oer_q;
  assign fer_o  = fer_q;
  assign per_o  = per_q;
  assign sum_o  = sum_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/uart_sleep_rx.sv
module uart_sleep_rx #(
  parameter int OSR = 16,
  parameter int W   = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         baud_tick_i,
  input  logic         rx_i,
  input  logic [1:0]   len_sel_i,
  input  logic         par_en_i,
  input  logic         par_odd_i,
  input  logic         sleep_i,
  input  logic         irq_err_only_i,
  input  logic         rbuf_rd_i,
  input  logic         re_wr_i,
  input  logic         re_wdata_i,
  output logic [W-1:0] rbuf_o,
  output logic         re_o,
  output logic         ri_o,
  output logic         oer_o,
  output logic         fer_o,
  output logic         per_o,
  output logic         sum_o,
  output logic         irq_o
);
  localparam int IW = $clog2(W + 1);

  logic          rx_s;
  logic [IW-1:0] nbits;
  logic [IW-1:0] top_idx;
  logic          frm_done, frm_ferr, frm_perr, frm_top;
  logic [W-1:0]  frm_data;

  assign nbits   = IW'(uart_rx_pkg::frame_bits(len_sel_i));
  assign top_idx = nbits - IW'(1);
  assign frm_top = frm_data[top_idx];

  uart_rx_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  uart_rx_frame #(.OSR(OSR), .W(W)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (re_o),
    .tick_i   (baud_tick_i),
    .rx_i     (rx_s),
    .nbits_i  (nbits),
    .par_en_i (par_en_i),
    .par_odd_i(par_odd_i),
    .done_o   (frm_done),
    .data_o   (frm_data),
    .ferr_o   (frm_ferr),
    .perr_o   (frm_perr)
  );

  uart_rx_status #(.W(W)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (frm_done),
    .data_i    (frm_data),
    .top_i     (frm_top),
    .ferr_i    (frm_ferr),
    .perr_i    (frm_perr),
    .sleep_i   (sleep_i),
    .err_only_i(irq_err_only_i),
    .rd_i      (rbuf_rd_i),
    .re_wr_i   (re_wr_i),
    .re_wdata_i(re_wdata_i),
    .rbuf_o    (rbuf_o),
    .re_o      (re_o),
    .ri_o      (ri_o),
    .oer_o     (oer_o),
    .fer_o     (fer_o),
    .per_o     (per_o),
    .sum_o     (sum_o),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/uart_sleep_rx_chk.sv
module uart_sleep_rx_chk #(
  parameter int W = 9
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         rbuf_rd_i,
  input logic         re_wr_i,
  input logic         re_wdata_i,
  input logic         par_en_i,
  input logic         sleep_i,
  input logic         frm_done,
  input logic         frm_top,
  input logic [W-1:0] rbuf_o,
  input logic         re_o,
  input logic         ri_o,
  input logic         oer_o,
  input logic         fer_o,
  input logic         per_o,
  input logic         sum_o,
  input logic         irq_o
);
  assert_sum_on_err_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(fer_o) || $rose(per_o) || $rose(oer_o)) |-> sum_o);

  assert_oer_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oer_o && !(re_wr_i && !re_wdata_i)) |=> oer_o);

  assert_read_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rbuf_rd_i && !frm_done) |=> (!ri_o && !fer_o && !per_o && !sum_o));

  assert_no_per_without_parity_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(per_o) |-> $past(par_en_i));

  assert_overrun_keeps_buf_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_done && re_o && ri_o && !rbuf_rd_i && !re_wr_i && (!sleep_i || frm_top))
    |=> (oer_o && ri_o && $stable(rbuf_o)));

  assert_sleep_drop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_done && sleep_i && !frm_top && !rbuf_rd_i && !re_wr_i)
    |=> ($stable({rbuf_o, ri_o, oer_o, fer_o, per_o, sum_o}) && !irq_o));

  assert_irq_from_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(frm_done));
endmodule

bind uart_sleep_rx uart_sleep_rx_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rbuf_rd_i (rbuf_rd_i),
  .re_wr_i   (re_wr_i),
  .re_wdata_i(re_wdata_i),
  .par_en_i  (par_en_i),
  .sleep_i   (sleep_i),
  .frm_done  (frm_done),
  .frm_top   (frm_top),
  .rbuf_o    (rbuf_o),
  .re_o      (re_o),
  .ri_o      (ri_o),
  .oer_o     (oer_o),
  .fer_o     (fer_o),
  .per_o     (per_o),
  .sum_o     (sum_o),
  .irq_o     (irq_o)
);

// File: tb/uart_sleep_rx_test.sv
module uart_sleep_rx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] tdiv;
  logic tick;
  logic rx = 1'b1;
  logic [1:0] len_sel = 2'd1;
  logic par_en = 1'b0, par_odd = 1'b0, sleep = 1'b0, err_only = 1'b0;
  logic rd = 1'b0, re_wr = 1'b0, re_wd = 1'b0;
  logic [8:0] rbuf;
  logic re, ri, oer, fer, per, sum, irq;

  int n_vec = 0, n_fail = 0, irq_cnt = 0;
  bit cmp_en = 1'b0;
  bit done_all = 1'b0;

  // reference state
  logic [8:0] m_rbuf = '0;
  bit m_re, m_ri, m_oer, m_fer, m_per, m_sum;
  int m_irq = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tdiv <= '0;
    else        tdiv <= tdiv + 2'd1;
  assign tick = (tdiv == 2'd3);

  uart_sleep_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .baud_tick_i(tick), .rx_i(rx),
    .len_sel_i(len_sel), .par_en_i(par_en), .par_odd_i(par_odd),
    .sleep_i(sleep), .irq_err_only_i(err_only), .rbuf_rd_i(rd),
    .re_wr_i(re_wr), .re_wdata_i(re_wd), .rbuf_o(rbuf), .re_o(re),
    .ri_o(ri), .oer_o(oer), .fer_o(fer), .per_o(per), .sum_o(sum), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cmp_all(input string req);
    chk({req, " rbuf R1"}, int'(rbuf), int'(m_rbuf));
    chk({req, " re R8"}, int'(re), int'(m_re));
    chk({req, " ri R6"}, int'(ri), int'(m_ri));
    chk({req, " oer R7"}, int'(oer), int'(m_oer));
    chk({req, " fer R4"}, int'(fer), int'(m_fer));
    chk({req, " per R3"}, int'(per), int'(m_per));
    chk({req, " sum R5"}, int'(sum), int'(m_sum));
    chk({req, err_only ? " irq R10" : " irq R9"}, irq_cnt, m_irq);
  endtask

  // per-clock comparison against the reference
  always @(posedge clk) begin
    #1;
    if (rst_n && irq) irq_cnt++;
    if (rst_n && cmp_en && !done_all) cmp_all("clk");
  end

  function automatic int nb();
    return (len_sel == 2'd0) ? 7 : (len_sel == 2'd1) ? 8 : 9;
  endfunction

  task automatic drive_bit(input logic v, input int clocks);
    rx = v;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic model_frame(input logic [8:0] d, input bit pe, input bit fe);
    int n = nb();
    logic [8:0] md = d & 9'((1 << n) - 1);
    if (!m_re) return;
    if (sleep && !md[n-1]) return;
    if (m_ri) begin
      m_oer = 1; m_sum = 1;
      if (err_only) m_irq++;
    end else begin
      m_rbuf = md; m_ri = 1; m_fer = fe; m_per = pe; m_sum = fe | pe;
      if (!err_only || fe || pe) m_irq++;
    end
  endtask

  task automatic send(input logic [8:0] d, input bit bad_par = 0, input bit bad_stop = 0);
    int n = nb();
    logic p = 1'b0;
    drive_bit(1'b0, 64);
    for (int i = 0; i < n; i++) begin
      p ^= d[i];
      drive_bit(d[i], 64);
    end
    if (par_en) drive_bit(p ^ par_odd ^ bad_par, 64);
    cmp_en = 0;
    if (bad_stop) begin
      drive_bit(1'b0, 44);
      drive_bit(1'b1, 20);
    end else drive_bit(1'b1, 64);
    model_frame(d, par_en && bad_par, bad_stop);
    cmp_en = 1;
    drive_bit(1'b1, 16);
  endtask

  task automatic do_read();
    @(negedge clk);
    rd = 1;
    m_ri = 0; m_fer = 0; m_per = 0; m_sum = 0;
    @(negedge clk);
    rd = 0;
  endtask

  task automatic do_re(input bit v);
    @(negedge clk);
    re_wr = 1; re_wd = v;
    m_re = v;
    if (!v) begin m_oer = 0; m_fer = 0; m_per = 0; m_sum = 0; end
    @(negedge clk);
    re_wr = 0;
  endtask

  task automatic finish_run();
    done_all = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp_all("R13 reset");
    chk("R13 irq idle", int'(irq), 0);
    cmp_en = 1;

    // disabled receiver ignores a frame
    send(9'h055);
    cmp_all("R8 disabled");
    do_re(1);

    // 8-bit plain frame
    send(9'h0A5);
    cmp_all("R1 8bit");
    chk("R9 irq count", irq_cnt, 1);
    do_read();
    cmp_all("R6 read");

    // 7-bit even parity, 9-bit odd parity
    len_sel = 2'd0; par_en = 1;
    send(9'h035);
    cmp_all("R1 7bit even");
    do_read();
    len_sel = 2'd2; par_odd = 1;
    send(9'h1C3);
    cmp_all("R1 9bit odd");
    chk("R1 rbuf 9bit", int'(rbuf), 'h1C3);
    do_read();

    // parity error, then framing error
    len_sel = 2'd1; par_odd = 0;
    send(9'h03C, 1, 0);
    chk("R3 per", int'(per), 1);
    chk("R5 sum", int'(sum), 1);
    do_read();
    cmp_all("R6 clear");
    par_en = 0;
    send(9'h081, 0, 1);
    chk("R4 fer", int'(fer), 1);
    chk("R3 per off", int'(per), 0);
    do_read();

    // overrun keeps earlier byte
    send(9'h011);
    send(9'h022);
    chk("R7 oer", int'(oer), 1);
    chk("R7 rbuf kept", int'(rbuf), 'h011);
    do_read();
    chk("R6 oer stays", int'(oer), 1);
    do_re(0);
    cmp_all("R8 clear");
    chk("R8 oer cleared", int'(oer), 0);
    do_re(1);

    // start glitch shorter than half a bit
    drive_bit(1'b0, 16);
    drive_bit(1'b1, 160);
    cmp_all("R2 glitch");

    // error-only interrupt policy
    err_only = 1;
    send(9'h066);
    chk("R10 no irq good", irq_cnt, m_irq);
    do_read();
    par_en = 1;
    send(9'h066, 1, 0);
    chk("R10 irq parity", irq_cnt, m_irq);
    do_read();
    par_en = 0;
    send(9'h012);
    send(9'h013);
    chk("R10 irq overrun", irq_cnt, m_irq);
    do_read();
    do_re(0);
    do_re(1);
    err_only = 0;

    // sleep filter, 8-bit
    sleep = 1;
    send(9'h005);
    cmp_all("R11 drop 8bit");
    send(9'h085);
    chk("R12 accept 8bit", int'(rbuf), 'h085);
    send(9'h001);
    chk("R11 no overrun", int'(oer), 0);
    do_read();
    // 7-bit: top is bit 6
    len_sel = 2'd0;
    send(9'h040);
    chk("R12 accept 7bit", int'(rbuf), 'h040);
    do_read();
    send(9'h03F);
    cmp_all("R11 drop 7bit");
    // 9-bit: top is bit 8
    len_sel = 2'd2;
    send(9'h0FF);
    cmp_all("R11 drop 9bit");
    send(9'h100);
    chk("R12 accept 9bit", int'(rbuf), 'h100);
    do_read();
    sleep = 0;

    repeat (10) @(negedge clk);
    cmp_all("final");
    finish_run();
  end
endmodule